// File: doc/BRIEF.md
# I2C Slave Interrupt Status Collector

This block sits beside an I2C slave engine and collects the single-cycle event strobes that the engine, its shared FIFOs and its DMA request logic raise. Each strobe sets a sticky bit in a raw status register. A per-source enable mask selects which bits reach the masked status and the single interrupt line. Software reads raw, mask and masked values through a small register port, and it clears events by writing ones to a clear address.

Three slave causes share one status bit: a transaction was received, the master asked for a transaction, or the next byte of a transfer is wanted. The remaining eight sources each have their own bit: start seen, stop seen, RX DMA pending, TX DMA pending, TX FIFO trigger level reached, RX FIFO trigger level reached, TX FIFO empty and RX FIFO full. A master-side register set would be a separate instance of the same block.

The register port is plain control: a write takes effect at the clock edge where `reg_wr_en` is high, and `reg_rdata` follows `reg_addr` combinationally with no back-pressure.

Top module: `i2cs_irq_top`

## Requirements
- R1: After reset the raw status, mask and masked status all read 0 and `irq_o` is low.
- R2: Status bit 0 (data) is set at the clock edge after any of `ev_rx_done`, `ev_rx_req` or `ev_next_byte` is high.
- R3: Each other source sets only its own bit: start 1, stop 2, DMA RX 3, DMA TX 4, TX level 5, RX level 6, TX empty 7, RX full 8.
- R4: A set raw bit stays set while no clear is written for it.
- R5: Writing to address 3 clears each raw bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R6: When an event and a clear hit the same bit in the same cycle, the bit is set afterwards.
- R7: Address 1 reads the raw bits unmasked; address 2 reads raw AND mask.
- R8: `irq_o` is high exactly when raw AND mask is non-zero.
- R9: Address 0 is the mask, readable and writable in bits 8:0; data bits above 8 read 0.
- R10: Writes to addresses 1 and 2 change neither the raw bits nor the mask.
- R11: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_done | input | 1 | Slave received a transaction (data bit) |
| ev_rx_req | input | 1 | Master requested a slave transaction (data bit) |
| ev_next_byte | input | 1 | Next byte of a transfer wanted (data bit) |
| ev_start | input | 1 | Start condition seen on the bus |
| ev_stop | input | 1 | Stop condition seen on the bus |
| ev_dma_rx | input | 1 | RX DMA interrupt pending |
| ev_dma_tx | input | 1 | TX DMA interrupt pending |
| ev_tx_level | input | 1 | TX FIFO trigger level reached |
| ev_rx_level | input | 1 | RX FIFO trigger level reached |
| ev_tx_empty | input | 1 | TX FIFO empty |
| ev_rx_full | input | 1 | RX FIFO full |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every strobe is pulsed alone, so a wrong bit position or a missing data cause shows as a one-hot mismatch. All 512 mask values are swept over a fully set raw register and over a spread of partial raw patterns, separating a wrong AND from a wrong OR on the interrupt line. All 512 clear patterns are written over a full raw register to expose any bit that clears too much or too little. Same-cycle event and clear, writes to read-only addresses and a read of the clear address cover the priority and decode corners.

// File: rtl/i2cs_irq_pkg.sv
package i2cs_irq_pkg;
  localparam int NSRC = 9;

  localparam int B_DATA     = 0;
  localparam int B_START    = 1;
  localparam int B_STOP     = 2;
  localparam int B_DMA_RX   = 3;
  localparam int B_DMA_TX   = 4;
  localparam int B_TX_LEVEL = 5;
  localparam int B_RX_LEVEL = 6;
  localparam int B_TX_EMPTY = 7;
  localparam int B_RX_FULL  = 8;

  typedef enum logic [1:0] {
    A_MASK   = 2'd0,
    A_RAW    = 2'd1,
    A_MASKED = 2'd2,
    A_CLEAR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2cs_ev_pack.sv
module i2cs_ev_pack #(
  parameter int N_DATA = 3,
  parameter int N_SOLO = 8,
  localparam int NOUT  = N_SOLO + 1
) (
  input  logic [N_DATA-1:0] data_causes,
  input  logic [N_SOLO-1:0] solo_events,
  output logic [NOUT-1:0]   set_vec
);
  always_comb begin
    set_vec    = '0;
    set_vec[0] = |data_causes;
    for (int i = 0; i < N_SOLO; i++) begin
      set_vec[i+1] = solo_events[i];
    end
  end
endmodule

// File: rtl/i2cs_raw_bank.sv
module i2cs_raw_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] raw_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          raw_q[g] <= 1'b0;
      else if (set_vec[g]) raw_q[g] <= 1'b1;
      else if (clr_vec[g]) raw_q[g] <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec))); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw_q) |=> ((raw_q & ($past(raw_q) & ~$past(clr_vec))) == ($past(raw_q) & ~$past(clr_vec)))); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0)); // R5
endmodule

// File: rtl/i2cs_mask_bank.sv
module i2cs_mask_bank #(
  parameter int          N   = 9,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= RST;
    else if (wr) mask_q <= wdata;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q)); // R9
endmodule

// File: rtl/i2cs_irq_top.sv
module i2cs_irq_top
  import i2cs_irq_pkg::*;
#(
  parameter int DW = 32,
  localparam int N = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx_done,
  input  logic          ev_rx_req,
  input  logic          ev_next_byte,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_dma_rx,
  input  logic          ev_dma_tx,
  input  logic          ev_tx_level,
  input  logic          ev_rx_level,
  input  logic          ev_tx_empty,
  input  logic          ev_rx_full,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  logic [2:0]   data_causes;
  logic [N-2:0] solo_events;
  logic [N-1:0] set_vec, clr_vec, raw_q, mask_q, masked;
  logic         wr_mask;
  reg_sel_e     sel;

  assign sel         = reg_sel_e'(reg_addr);
  assign data_causes = {ev_next_byte, ev_rx_req, ev_rx_done};
  assign solo_events = {ev_rx_full, ev_tx_empty, ev_rx_level, ev_tx_level,
                        ev_dma_tx, ev_dma_rx, ev_stop, ev_start};

  i2cs_ev_pack #(.N_DATA(3), .N_SOLO(N-1)) u_pack (
    .data_causes (data_causes),
    .solo_events (solo_events),
    .set_vec     (set_vec)
  );

  assign wr_mask = reg_wr_en && (sel == A_MASK);
  assign clr_vec = (reg_wr_en && (sel == A_CLEAR)) ? reg_wdata[N-1:0] : '0;

  i2cs_raw_bank #(.N(N)) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .raw_q   (raw_q)
  );

  i2cs_mask_bank #(.N(N), .RST('0)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_mask),
    .wdata  (reg_wdata[N-1:0]),
    .mask_q (mask_q)
  );

  assign masked = raw_q & mask_q;
  assign irq_o  = |masked;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      A_MASK:   reg_rdata[N-1:0] = mask_q;
      A_RAW:    reg_rdata[N-1:0] = raw_q;
      A_MASKED: reg_rdata[N-1:0] = masked;
      A_CLEAR:  reg_rdata        = '0;
      default:  reg_rdata        = '0;
    endcase
  end

  AST_DATA_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done || ev_rx_req || ev_next_byte) |=> raw_q[B_DATA]); // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((mask_q != '0) && (raw_q != '0))); // R8
  AST_RO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (sel == A_RAW || sel == A_MASKED) && set_vec == '0) |=> $stable(raw_q)); // R10
  AST_RO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && sel != A_MASK) |=> $stable(mask_q)); // R10
endmodule

// File: tb/i2cs_irq_top_tb.sv
module i2cs_irq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;
  localparam logic [31:0] FULL = 32'h1FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] ev = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_irq_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_done(ev[0]), .ev_rx_req(ev[1]), .ev_next_byte(ev[2]),
    .ev_start(ev[3]), .ev_stop(ev[4]), .ev_dma_rx(ev[5]), .ev_dma_tx(ev[6]),
    .ev_tx_level(ev[7]), .ev_rx_level(ev[8]), .ev_tx_empty(ev[9]), .ev_rx_full(ev[10]),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] ev_for(input logic [8:0] st);
    logic [10:0] v = '0;
    v[0] = st[0];
    for (int b = 1; b < N; b++) v[b+2] = st[b];
    return v;
  endfunction

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd1, d); check("R1 raw", d, 0);
    rd(2'd0, d); check("R1 mask", d, 0);
    rd(2'd2, d); check("R1 masked", d, 0);
    check("R1 irq", {31'd0, irq_o}, 0);

    // R2 / R3 / R4: each strobe alone
    for (int i = 0; i < 11; i++) begin
      logic [31:0] exp;
      exp = 32'd1 << ((i < 3) ? 0 : i - 2);
      pulse(11'd1 << i);
      rd(2'd1, d); check((i < 3) ? "R2 data cause" : "R3 solo source", d, exp);
      repeat (5) @(negedge clk);
      rd(2'd1, d); check("R4 sticky", d, exp);
      check("R8 irq masked off", {31'd0, irq_o}, 0);
      wr(2'd3, FULL);
      rd(2'd1, d); check("R5 full clear", d, 0);
    end

    // R9 mask read/write width
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R9 mask width", d, FULL);
    wr(2'd0, 32'h0000_0155);
    rd(2'd0, d); check("R9 mask value", d, 32'h155);
    // R11 clear address reads zero
    rd(2'd3, d); check("R11 clear reads 0", d, 0);

    // R7 / R8: full mask sweep over full raw
    pulse(11'h7FF);
    for (int m = 0; m < 512; m++) begin
      wr(2'd0, m);
      rd(2'd2, d); check("R7 masked", d, m);
      rd(2'd1, d); check("R7 raw unmasked", d, FULL);
      check("R8 irq", {31'd0, irq_o}, (m != 0) ? 1 : 0);
    end
    wr(2'd3, FULL);

    // R7 / R8: partial raw patterns
    for (int r = 1; r < 512; r += 37) begin
      pulse(ev_for(r[8:0]));
      for (int m = 0; m < 512; m += 29) begin
        wr(2'd0, m);
        rd(2'd2, d); check("R7 partial masked", d, r & m);
        check("R8 partial irq", {31'd0, irq_o}, ((r & m) != 0) ? 1 : 0);
      end
      wr(2'd3, FULL);
    end
    wr(2'd0, 0);

    // R5 clear pattern sweep
    for (int p = 0; p < 512; p++) begin
      pulse(11'h7FF);
      wr(2'd3, p);
      rd(2'd1, d); check("R5 partial clear", d, FULL & ~p);
      wr(2'd3, FULL);
    end

    // R6 same-cycle event and clear, bit clear beforehand
    @(negedge clk); ev = 11'd1 << 3; reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = FULL;
    @(negedge clk); ev = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    rd(2'd1, d); check("R6 set beats clear", d, 32'h002);
    // R6 with bit already set, others cleared
    pulse(ev_for(9'h180));
    @(negedge clk); ev = 11'd1 << 10; reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = FULL;
    @(negedge clk); ev = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    rd(2'd1, d); check("R6 set beats clear held", d, 32'h100);
    wr(2'd3, FULL);

    // R10 writes to read-only addresses
    wr(2'd0, 32'h0A5);
    pulse(ev_for(9'h0F0));
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd1, FULL);
    rd(2'd1, d); check("R10 raw untouched", d, 32'h0F0);
    rd(2'd0, d); check("R10 mask untouched", d, 32'h0A5);
    rd(2'd2, d); check("R7 masked after RO writes", d, 32'h0A0);
    check("R8 irq after RO writes", {31'd0, irq_o}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule